// File: doc/BRIEF.md
# Per-processor interrupt presentation unit

This block sits next to one processor and decides whether that processor should be interrupted right now. External sources post requests into a small set of pending slots. Each request carries a 24-bit source number and an 8-bit priority. Software on the processor can also post an interprocessor request by writing a priority byte. The unit keeps the processor's current priority. It compares the most urgent pending request against that priority and drives a single registered interrupt line.

Software reaches the unit through four 32-bit words. One word both accepts the interrupt and raises the processor priority when it is read. Writing a full word to the same location restores the priority and reports end-of-interrupt for the source it names. A second word gives the same view as the accepting word without any side effect. Priorities count downwards: 0x00 is the most urgent value and 0xff the least. A current priority of 0xff admits every request, and a current priority of 0x00 admits none.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the current priority is 0x00, the interprocessor priority is 0xff, no slot is pending, and `irq_o` and `eoi_vld_o` are low.
- R2: `irq_o` is high one cycle after a state in which the best pending priority is strictly below the current priority. It is low otherwise, so a current priority of 0x00 blocks everything and an equal priority does not qualify.
- R3: The winner is the request with the numerically smallest priority. The interprocessor request beats a slot of equal priority, and among slots of equal priority the lower slot index wins. A priority of 0xff never wins.
- R4: A read of word 1 while a request qualifies returns {current priority, winning source} in bits 31:24 and 23:0 during the read cycle. At the closing clock edge it sets the current priority to the winner's priority and clears the winner's pending state.
- R5: A read of word 1 while nothing qualifies returns {current priority, 0x000000} and changes no state.
- R6: A read of word 0 returns the same value as word 1 would, and it changes no state.
- R7: A write to word 1 with only byte enable 3 (bits 31:24) sets the current priority to those bits and does not raise `eoi_vld_o`.
- R8: A write to word 1 with all four byte enables sets the current priority to bits 31:24. In the following cycle it raises `eoi_vld_o` for one cycle with `eoi_src_o` equal to bits 23:0.
- R9: A write to word 3 with byte enable 3 sets the interprocessor priority from bits 31:24, and 0xff withdraws the request. The request is presented as source number 2 and is withdrawn when it is accepted. Word 3 reads back {interprocessor priority, 0x000000}. Word 2 reads as zero and ignores writes.
- R10: `irq_o` is low in the cycle after an accepting read. In the cycle after that it is high again if another request still qualifies.
- R11: A pulse on `slot_set_i[i]` marks slot i pending with the source and priority present on its lanes and overwrites any earlier request in that slot. It takes precedence over clearing the same slot by an accepting read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_set_i | input | NSLOT | Per-slot request strobe |
| slot_src_i | input | NSLOT*24 | Per-slot source number, slot i in lane i |
| slot_pri_i | input | NSLOT*8 | Per-slot priority, slot i in lane i |
| bus_rd_i | input | 1 | Register read strobe (ignored while bus_wr_i is high) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Word index 0..3 |
| bus_be_i | input | 4 | Byte enables, bit 3 covers data bits 31:24 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational while bus_rd_i is high, zero otherwise |
| irq_o | output | 1 | Registered interrupt level to the processor |
| eoi_vld_o | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_src_o | output | 24 | Source number that accompanies the pulse |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it one nanosecond after driving at the falling edge, before the edge that commits the side effects. State changes land at the rising edge that ends each access. `irq_o` follows one rising edge later, so the bench checks it twice: right after the access edge, where it still shows the old state or the drop after an acceptance, and again after the next edge, where it shows the new state. The end-of-interrupt pulse is checked right after the edge that takes the full-word write.

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
  parameter int NSLOT   = 4,
  parameter int SRC_W   = 24,
  parameter int PRI_W   = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       slot_set_i,
  input  logic [NSLOT*SRC_W-1:0] slot_src_i,
  input  logic [NSLOT*PRI_W-1:0] slot_pri_i,
  input  logic                   bus_rd_i,
  input  logic                   bus_wr_i,
  input  logic [1:0]             bus_addr_i,
  input  logic [3:0]             bus_be_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  output logic                   irq_o,
  output logic                   eoi_vld_o,
  output logic [SRC_W-1:0]       eoi_src_o
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam logic [PRI_W-1:0] PRI_NONE = '1;
  localparam logic [1:0] W_POLL = 2'd0, W_ACK = 2'd1, W_GAP = 2'd2, W_IPI = 2'd3;

  logic [PRI_W-1:0] cppr, ipi_pri;
  logic [NSLOT-1:0] pend;
  logic [PRI_W-1:0] spri [NSLOT];
  logic [SRC_W-1:0] ssrc [NSLOT];

  logic [PRI_W-1:0] best_pri;
  logic [SRC_W-1:0] best_src;
  logic             win_ipi, win_slot;
  logic [IDX_W-1:0] win_idx;
  logic             best_vld, ack_fire;
  logic             wr_ack, wr_ipi, wr_eoi;

  always_comb begin
    best_pri = ipi_pri;
    win_ipi  = (ipi_pri != PRI_NONE);
    best_src = win_ipi ? SRC_W'(IPI_SRC) : '0;
    win_slot = 1'b0;
    win_idx  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (pend[i] && (spri[i] < best_pri)) begin
        best_pri = spri[i];
        best_src = ssrc[i];
        win_ipi  = 1'b0;
        win_slot = 1'b1;
        win_idx  = IDX_W'(i);
      end
    end
  end

  assign best_vld = (win_ipi || win_slot) && (best_pri < cppr);
  assign ack_fire = bus_rd_i && !bus_wr_i && (bus_addr_i == W_ACK) && best_vld;
  assign wr_ack   = bus_wr_i && (bus_addr_i == W_ACK) && bus_be_i[3];
  assign wr_eoi   = bus_wr_i && (bus_addr_i == W_ACK) && (bus_be_i == 4'hf);
  assign wr_ipi   = bus_wr_i && (bus_addr_i == W_IPI) && bus_be_i[3];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      case (bus_addr_i)
        W_POLL, W_ACK: bus_rdata_o = {cppr, best_vld ? best_src : SRC_W'(0)};
        W_GAP:         bus_rdata_o = '0;
        default:       bus_rdata_o = {ipi_pri, SRC_W'(0)};
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[g] <= 1'b0;
          spri[g] <= PRI_NONE;
          ssrc[g] <= '0;
        end else if (slot_set_i[g]) begin
          pend[g] <= 1'b1;
          spri[g] <= slot_pri_i[g*PRI_W +: PRI_W];
          ssrc[g] <= slot_src_i[g*SRC_W +: SRC_W];
        end else if (ack_fire && win_slot && (win_idx == IDX_W'(g))) begin
          pend[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr      <= '0;
      ipi_pri   <= PRI_NONE;
      irq_o     <= 1'b0;
      eoi_vld_o <= 1'b0;
      eoi_src_o <= '0;
    end else begin
      if (wr_ack)        cppr <= bus_wdata_i[31:24];
      else if (ack_fire) cppr <= best_pri;

      if (wr_ipi)                   ipi_pri <= bus_wdata_i[31:24];
      else if (ack_fire && win_ipi) ipi_pri <= PRI_NONE;

      irq_o     <= best_vld && !ack_fire;
      eoi_vld_o <= wr_eoi;
      if (wr_eoi) eoi_src_o <= bus_wdata_i[SRC_W-1:0];
    end
  end

  p_ack_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_o);

  p_closed_blocks_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr == '0) |=> !irq_o);

  p_ack_raises_urgency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (cppr < $past(cppr)));

  p_eoi_needs_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_vld_o |-> $past(bus_wr_i && (bus_addr_i == W_ACK) && (bus_be_i == 4'hf)));

  p_poll_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_wr_i && (bus_addr_i == W_POLL)) |=> ($stable(cppr) && $stable(ipi_pri)));

  p_ipi_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && win_ipi) |=> (ipi_pri == PRI_NONE));

  p_eoi_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld_o && !$past(wr_eoi, 2)) |=> !eoi_vld_o || $past(wr_eoi));
endmodule

// File: tb/tb_irq_present_unit.sv
module tb_irq_present_unit;
  localparam int NSLOT = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSLOT-1:0]    slot_set = '0;
  logic [NSLOT*24-1:0] slot_src = '0;
  logic [NSLOT*8-1:0]  slot_pri = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, eoi_vld;
  logic [23:0] eoi_src;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_present_unit #(.NSLOT(NSLOT)) dut (
    .clk(clk), .rst_n(rst_n), .slot_set_i(slot_set), .slot_src_i(slot_src),
    .slot_pri_i(slot_pri), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_be_i(bus_be), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .eoi_vld_o(eoi_vld), .eoi_src_o(eoi_src));

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  adr;
    logic [3:0]  be;
    logic [31:0] dat;
    logic [31:0] exp;
    logic        irq_now;
    logic        irq_next;
    logic        eoi;
  } vec_t;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_SET = 2'd2;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{K_RD,  2'd0, 4'h0, 32'h0,          32'h00000000, 1'b0, 1'b0, 1'b0},
    '{K_SET, 2'd0, 4'h0, 32'h10000123,   32'h0,        1'b0, 1'b0, 1'b0},
    '{K_WR,  2'd1, 4'h8, 32'hFF000000,   32'h0,        1'b0, 1'b1, 1'b0},
    '{K_RD,  2'd0, 4'h0, 32'h0,          32'hFF000123, 1'b1, 1'b1, 1'b0},
    '{K_SET, 2'd1, 4'h0, 32'h08000456,   32'h0,        1'b1, 1'b1, 1'b0},
    '{K_WR,  2'd3, 4'h8, 32'h08000000,   32'h0,        1'b1, 1'b1, 1'b0},
    '{K_RD,  2'd1, 4'h0, 32'h0,          32'hFF000002, 1'b0, 1'b0, 1'b0},
    '{K_RD,  2'd3, 4'h0, 32'h0,          32'hFF000000, 1'b0, 1'b0, 1'b0},
    '{K_RD,  2'd1, 4'h0, 32'h0,          32'h08000000, 1'b0, 1'b0, 1'b0},
    '{K_WR,  2'd1, 4'hF, 32'hFF000002,   32'h0,        1'b0, 1'b1, 1'b1},
    '{K_RD,  2'd1, 4'h0, 32'h0,          32'hFF000456, 1'b0, 1'b0, 1'b0},
    '{K_WR,  2'd1, 4'hF, 32'h10000456,   32'h0,        1'b0, 1'b0, 1'b1},
    '{K_WR,  2'd1, 4'h8, 32'h11000000,   32'h0,        1'b0, 1'b1, 1'b0},
    '{K_RD,  2'd1, 4'h0, 32'h0,          32'h11000123, 1'b0, 1'b0, 1'b0},
    '{K_WR,  2'd2, 4'hF, 32'h12345678,   32'h0,        1'b0, 1'b0, 1'b0},
    '{K_RD,  2'd2, 4'h0, 32'h0,          32'h00000000, 1'b0, 1'b0, 1'b0},
    '{K_RD,  2'd0, 4'h0, 32'h0,          32'h10000000, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] kind, input logic [1:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [31:0] exp, input string tag);
    @(negedge clk);
    case (kind)
      K_WR: begin bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d; end
      K_RD: begin bus_rd = 1'b1; bus_addr = a; end
      default: begin
        slot_set[a] = 1'b1;
        slot_src[a*24 +: 24] = d[23:0];
        slot_pri[a*8 +: 8] = d[31:24];
      end
    endcase
    #1;
    if (kind == K_RD) chk(tag, bus_rdata, exp);
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0; slot_set = '0;
  endtask

  task automatic poll(input logic [31:0] exp, input string tag);
    step(K_RD, 2'd0, 4'h0, 32'h0, exp, tag);
  endtask

  task automatic irq_after_edge(input logic exp, input string tag);
    @(posedge clk);
    #1;
    chk(tag, {31'h0, irq}, {31'h0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 eoi after reset", {31'h0, eoi_vld}, 32'h0);
    step(K_RD, 2'd3, 4'h0, 32'h0, 32'hFF000000, "R1 ipi word reset");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].kind, VEC[i].adr, VEC[i].be, VEC[i].dat, VEC[i].exp,
           $sformatf("R4/R5/R6/R9 vector %0d rdata", i));
      chk($sformatf("R10 vector %0d irq at edge", i), {31'h0, irq}, {31'h0, VEC[i].irq_now});
      chk($sformatf("R7/R8 vector %0d eoi", i), {31'h0, eoi_vld}, {31'h0, VEC[i].eoi});
      if (VEC[i].eoi) chk($sformatf("R8 vector %0d eoi src", i), {8'h0, eoi_src}, {8'h0, VEC[i].dat[23:0]});
      irq_after_edge(VEC[i].irq_next, $sformatf("R2 vector %0d irq next", i));
    end

    // R3: equal slot priorities, lower index wins
    step(K_WR, 2'd1, 4'h8, 32'hFF000000, 32'h0, "R7 open");
    step(K_SET, 2'd3, 4'h0, 32'h20000333, 32'h0, "R11 set3");
    step(K_SET, 2'd2, 4'h0, 32'h20000222, 32'h0, "R11 set2");
    poll(32'hFF000222, "R3 slot tie");

    // R9: interprocessor request beats, then withdrawn by 0xff
    step(K_WR, 2'd3, 4'h8, 32'h01000000, 32'h0, "R9 post");
    poll(32'hFF000002, "R9 ipi wins");
    step(K_RD, 2'd3, 4'h0, 32'h0, 32'h01000000, "R9 readback");
    step(K_WR, 2'd3, 4'h8, 32'hFF000000, 32'h0, "R9 withdraw");
    poll(32'hFF000222, "R9 after withdraw");

    // R11: new request to slot 2 in the same cycle as it is accepted
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd1;
    slot_set[2] = 1'b1; slot_src[2*24 +: 24] = 24'h0002AA; slot_pri[2*8 +: 8] = 8'h30;
    #1 chk("R4 ack slot2", bus_rdata, 32'hFF000222);
    @(posedge clk);
    #1 bus_rd = 1'b0; slot_set = '0;
    poll(32'h20000000, "R4 cppr raised");
    step(K_WR, 2'd1, 4'h8, 32'hFF000000, 32'h0, "R7 reopen");
    poll(32'hFF000333, "R11 slot3 before new slot2");
    step(K_RD, 2'd1, 4'h0, 32'h0, 32'hFF000333, "R4 ack slot3");
    poll(32'h20000000, "R11 equal not taken");
    step(K_WR, 2'd1, 4'h8, 32'hFF000000, 32'h0, "R7 reopen2");
    poll(32'hFF0002AA, "R11 set kept over clear");

    // R11: overwrite of a pending slot
    step(K_SET, 2'd2, 4'h0, 32'h050002BB, 32'h0, "R11 overwrite");
    poll(32'hFF0002BB, "R11 overwritten value");

    // R2: closed, just above, and equal current priority
    step(K_WR, 2'd1, 4'h8, 32'h00000000, 32'h0, "R7 close");
    irq_after_edge(1'b0, "R2 closed irq");
    poll(32'h00000000, "R2 closed poll");
    step(K_WR, 2'd1, 4'h8, 32'h06000000, 32'h0, "R7 to 06");
    irq_after_edge(1'b1, "R2 05 below 06");
    step(K_WR, 2'd1, 4'h8, 32'h05000000, 32'h0, "R7 to 05");
    chk("R7 no eoi on byte write", {31'h0, eoi_vld}, 32'h0);
    irq_after_edge(1'b0, "R2 equal blocks");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule